// File: doc/BRIEF.md
# Interrupt, Halt and Reset Controller

This block is the event and control hub beside a command engine that drives two I2C masters, each with two command queues. Single-cycle event pulses from the masters and queues are caught in a 32-bit sticky status word. A mask word with the same layout gates that status onto one level interrupt line. Two per-master error flags summarise each master's error bits.

Software clears status in two steps. It first writes the bits it wants removed into a pending-clear word, and nothing changes yet. It then writes a commit command, which removes those bits in one cycle.

The same 32-bit register bus also starts two kinds of operation. A per-master halt holds the chosen master idle and flushed for a fixed number of cycles and then posts a halt acknowledge. A masked soft reset holds every master named by its mask idle for a fixed number of cycles and then posts reset-done.

Top module: `irq_hub_ctrl`

## Requirements
- R1: A pulse on `ev_rd_done[m]` sets status bit 12*m. A pulse on `ev_q_report[2*m+q]` sets status bit 12*m+4+4*q, where m is the master (0 or 1) and q is the queue (0 or 1).
- R2: A pulse on `ev_nack[2*m+q]` sets status bit 27+2*m+q.
- R3: A pulse on `ev_fault[8*m+k]` sets status bit 12*m+P[k], where P = {1,2,5,6,7,9,10,11}. `master_err[0]` is high while any bit of status AND 0x18000EE6 is set. `master_err[1]` is high while any bit of status AND 0x60EE6000 is set.
- R4: The mask register sits at address 1 and has the status layout. `irq` is high exactly while (status AND mask) is nonzero.
- R5: Status bits stay set until a commit clears them. A read at address 0 returns the raw, unmasked status.
- R6: A write to address 2 loads the pending-clear word, which reads back at address 2 and leaves status unchanged. A write to address 3 with data bit 0 set clears the pending bits from status and empties the pending word. A write to address 3 with bit 0 clear does nothing.
- R7: An event that arrives in the same cycle as a commit that would clear its bit leaves that bit set.
- R8: A write to address 4 with bit m set starts a halt of master m. `master_hold[m]` is high for exactly HALT_LAT cycles after the write, and then status bit 25+m is set. The other master's hold is not affected. A new halt request for a master that is already halting is ignored.
- R9: A nonzero write to address 5 starts a soft reset. Master 0 is affected when the data has a bit in 0x000003F0, and master 1 when it has a bit in 0x0003F000. The affected holds are high for exactly RST_LAT cycles, and then status bit 24 is set. A zero write starts nothing.
- R10: After reset, status, mask, the pending-clear word, `irq`, `master_err` and `master_hold` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 32 | Read data (combinational) |
| ev_rd_done | input | 2 | Read-done pulses, one per master |
| ev_q_report | input | 4 | Queue report pulses, index 2*m+q |
| ev_nack | input | 4 | NACK error pulses, index 2*m+q |
| ev_fault | input | 16 | Other error pulses, index 8*m+k |
| irq | output | 1 | Level interrupt |
| master_err | output | 2 | Per-master error summary |
| master_hold | output | 2 | Hold idle and flush queues, per master |

## Verification
The bench builds the block with HALT_LAT=3 and RST_LAT=5. With these values the hold windows are short enough to count edge by edge, and distinct enough that a halt window cannot be mistaken for a reset window. A second halt request issued inside a running window would lengthen it by a visible amount if it were not ignored. The reset masks used are the master-0-only mask, the full-controller mask and a zero mask, so hold selection is seen for one master, for both, and for none.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int NM      = 2;   // masters
  localparam int NQ      = 2;   // queues per master
  localparam int NF      = 8;   // non-NACK error sources per master
  localparam int DW      = 32;
  localparam int AW      = 3;
  localparam int MSTRIDE = 12;  // bit distance between master groups

  localparam int RST_DONE_BIT  = 24;
  localparam int HALT_ACK_BASE = 25;
  localparam int NACK_BASE     = 27;

  localparam logic [AW-1:0] A_STATUS = 3'd0;
  localparam logic [AW-1:0] A_MASK   = 3'd1;
  localparam logic [AW-1:0] A_CLEAR  = 3'd2;
  localparam logic [AW-1:0] A_COMMIT = 3'd3;
  localparam logic [AW-1:0] A_HALT   = 3'd4;
  localparam logic [AW-1:0] A_RESET  = 3'd5;

  // status bit of the k-th non-NACK error source of master m
  function automatic int fault_pos(input int m, input int k);
    int base;
    case (k)
      0: base = 1;
      1: base = 2;
      2: base = 5;
      3: base = 6;
      4: base = 7;
      5: base = 9;
      6: base = 10;
      default: base = 11;
    endcase
    return m * MSTRIDE + base;
  endfunction

  function automatic logic [DW-1:0] err_group(input int m);
    return (m == 0) ? 32'h18000EE6 : 32'h60EE6000;
  endfunction

  // reset-mask bits that select a master for holding
  function automatic logic [DW-1:0] rst_scope(input int m);
    return (m == 0) ? 32'h000003F0 : 32'h0003F000;
  endfunction

  function automatic logic [DW-1:0] pack_events(
    input logic [NM-1:0]    rd,
    input logic [NM*NQ-1:0] rep,
    input logic [NM*NQ-1:0] nack,
    input logic [NM*NF-1:0] fault
  );
    logic [DW-1:0] v;
    v = '0;
    for (int m = 0; m < NM; m++) begin
      v[m*MSTRIDE] = rd[m];
      for (int q = 0; q < NQ; q++) begin
        v[m*MSTRIDE + 4 + 4*q]   = rep[m*NQ + q];
        v[NACK_BASE + m*NQ + q]  = nack[m*NQ + q];
      end
      for (int k = 0; k < NF; k++)
        v[fault_pos(m, k)] = fault[m*NF + k];
    end
    return v;
  endfunction

endpackage

// File: rtl/irq_hub_timer.sv
module irq_hub_timer #(
  parameter int unsigned LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= LOAD;
      end
    end else begin
      if (cnt == ONE) busy <= 1'b0;
      cnt <= cnt - ONE;
    end
  end

  // R8 / R9: a running window counts down and is not restarted
  assert_window_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == $past(cnt) - ONE));
  // R9: the window ends right after its done cycle
  assert_window_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_data,
  input  logic          commit,
  output logic [DW-1:0] status,
  output logic [DW-1:0] pending
);
  logic [DW-1:0] kill;

  assign kill = commit ? pending : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      pending <= '0;
    end else begin
      status <= (status & ~kill) | set_vec;
      if (commit)      pending <= '0;
      else if (clr_wr) pending <= clr_data;
    end
  end

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ((status & $past(status)) == $past(status)));
  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((status & $past(pending) & ~$past(set_vec)) == '0));
  assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int unsigned HALT_LAT = 16,
  parameter int unsigned RST_LAT  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic [AW-1:0]       bus_raddr,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NM-1:0]       ev_rd_done,
  input  logic [NM*NQ-1:0]    ev_q_report,
  input  logic [NM*NQ-1:0]    ev_nack,
  input  logic [NM*NF-1:0]    ev_fault,
  output logic                irq,
  output logic [NM-1:0]       master_err,
  output logic [NM-1:0]       master_hold
);
  // decoded write events
  logic wr_mask, wr_clear, wr_commit, wr_halt, wr_reset;
  assign wr_mask   = bus_wr && (bus_addr == A_MASK);
  assign wr_clear  = bus_wr && (bus_addr == A_CLEAR);
  assign wr_commit = bus_wr && (bus_addr == A_COMMIT) && bus_wdata[0];
  assign wr_halt   = bus_wr && (bus_addr == A_HALT);
  assign wr_reset  = bus_wr && (bus_addr == A_RESET) && (|bus_wdata);

  logic [DW-1:0] mask_q, status_q, pending_q, set_vec, ack_vec;
  logic [NM-1:0] halt_busy, halt_done, rst_sel;
  logic          rst_busy, rst_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata;
  end

  // per-master halt windows
  for (genvar m = 0; m < NM; m++) begin : g_halt
    irq_hub_timer #(.LAT(HALT_LAT)) u_halt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_halt && bus_wdata[m]),
      .busy  (halt_busy[m]),
      .done  (halt_done[m])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rst_sel[m] <= 1'b0;
      else if (wr_reset && !rst_busy) rst_sel[m] <= |(bus_wdata & rst_scope(m));
    end

    assign master_hold[m] = halt_busy[m] || (rst_busy && rst_sel[m]);
    assign master_err[m]  = |(status_q & err_group(m));

    assert_halt_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[HALT_ACK_BASE + m]) |-> $past(halt_done[m]));
  end

  // soft reset window
  irq_hub_timer #(.LAT(RST_LAT)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_reset),
    .busy  (rst_busy),
    .done  (rst_done)
  );

  always_comb begin
    ack_vec = '0;
    ack_vec[RST_DONE_BIT] = rst_done;
    for (int m = 0; m < NM; m++) ack_vec[HALT_ACK_BASE + m] = halt_done[m];
  end

  assign set_vec = pack_events(ev_rd_done, ev_q_report, ev_nack, ev_fault) | ack_vec;

  irq_hub_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (wr_clear),
    .clr_data (bus_wdata),
    .commit   (wr_commit),
    .status   (status_q),
    .pending  (pending_q)
  );

  assign irq = |(status_q & mask_q);

  always_comb begin
    case (bus_raddr)
      A_STATUS: bus_rdata = status_q;
      A_MASK:   bus_rdata = mask_q;
      A_CLEAR:  bus_rdata = pending_q;
      default:  bus_rdata = '0;
    endcase
  end

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  assert_rst_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[RST_DONE_BIT]) |-> $past(rst_done));

endmodule

// File: tb/test_irq_hub_ctrl.sv
module test_irq_hub_ctrl;
  localparam int HL = 3;
  localparam int RL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  ev_rd_done = '0;
  logic [3:0]  ev_q_report = '0;
  logic [3:0]  ev_nack = '0;
  logic [15:0] ev_fault = '0;
  logic        irq;
  logic [1:0]  master_err;
  logic [1:0]  master_hold;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  irq_hub_ctrl #(.HALT_LAT(HL), .RST_LAT(RL)) i_irq_hub_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .ev_rd_done(ev_rd_done), .ev_q_report(ev_q_report), .ev_nack(ev_nack),
    .ev_fault(ev_fault), .irq(irq), .master_err(master_err),
    .master_hold(master_hold)
  );

  typedef struct packed {
    logic [1:0]  rd;
    logic [3:0]  rep;
    logic [3:0]  nack;
    logic [15:0] fault;
    logic [31:0] mask;
    logic [31:0] stat;
    logic        irq;
    logic [1:0]  err;
  } vec_t;

  // R1 R2 R3 R4 vectors
  localparam vec_t VEC [8] = '{
    '{2'b01, 4'h0, 4'h0, 16'h0000, 32'h00000001, 32'h00000001, 1'b1, 2'b00},
    '{2'b10, 4'h0, 4'h0, 16'h0000, 32'h00000001, 32'h00001000, 1'b0, 2'b00},
    '{2'b00, 4'h5, 4'h0, 16'h0000, 32'h00010000, 32'h00010010, 1'b1, 2'b00},
    '{2'b00, 4'hA, 4'h0, 16'h0000, 32'h00000000, 32'h00100100, 1'b0, 2'b00},
    '{2'b00, 4'h0, 4'h9, 16'h0000, 32'hFFFFFFFF, 32'h48000000, 1'b1, 2'b11},
    '{2'b00, 4'h0, 4'h0, 16'h00FF, 32'h18000EE6, 32'h00000EE6, 1'b1, 2'b01},
    '{2'b00, 4'h0, 4'h0, 16'hFF00, 32'h18000EE6, 32'h00EE6000, 1'b0, 2'b10},
    '{2'b00, 4'h0, 4'h0, 16'h0101, 32'h00002000, 32'h00002002, 1'b1, 2'b11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_all();
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd3, 32'h1);
    wr(3'd1, 32'h0);
  endtask

  // counts cycles master_hold[idx] stays high; notes if other hold differs
  task automatic count_hold(input int idx, output int n, output logic other_seen);
    n = 0; other_seen = 1'b0;
    while (master_hold[idx] && n < 50) begin
      n++;
      if (master_hold[1-idx]) other_seen = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int n;
    logic oth;
    repeat (3) @(negedge clk);
    // R10 reset values
    rd(3'd0, r); check("R10 status", r, 0);
    rd(3'd1, r); check("R10 mask", r, 0);
    rd(3'd2, r); check("R10 pending", r, 0);
    check("R10 outs", {27'd0, irq, master_err, master_hold}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      clear_all();
      wr(3'd1, VEC[i].mask);
      ev_rd_done = VEC[i].rd; ev_q_report = VEC[i].rep;
      ev_nack = VEC[i].nack; ev_fault = VEC[i].fault;
      @(negedge clk);
      ev_rd_done = '0; ev_q_report = '0; ev_nack = '0; ev_fault = '0;
      rd(3'd0, r); check($sformatf("R1 R2 R3 status vec%0d", i), r, VEC[i].stat);
      check($sformatf("R4 irq vec%0d", i), {31'd0, irq}, {31'd0, VEC[i].irq});
      check($sformatf("R3 err vec%0d", i), {30'd0, master_err}, {30'd0, VEC[i].err});
    end

    // R6 two-step clear
    clear_all();
    ev_rd_done = 2'b11; @(negedge clk); ev_rd_done = '0;
    wr(3'd2, 32'h1);
    rd(3'd0, r); check("R6 no clear before commit", r, 32'h00001001);
    rd(3'd2, r); check("R6 pending readback", r, 32'h1);
    wr(3'd3, 32'h0);
    rd(3'd0, r); check("R6 commit bit0 clear ignored", r, 32'h00001001);
    wr(3'd3, 32'h1);
    rd(3'd0, r); check("R6 commit clears", r, 32'h00001000);
    rd(3'd2, r); check("R6 pending emptied", r, 32'h0);

    // R7 event coinciding with commit
    clear_all();
    ev_q_report = 4'b0001; @(negedge clk); ev_q_report = '0;
    wr(3'd2, 32'h10);
    ev_q_report = 4'b0001;
    wr(3'd3, 32'h1);
    ev_q_report = '0;
    rd(3'd0, r); check("R7 event kept on commit", r, 32'h10);

    // R4 mask change, R5 raw readback
    check("R4 irq masked off", {31'd0, irq}, 0);
    wr(3'd1, 32'h10);
    check("R4 irq after mask", {31'd0, irq}, 1);
    wr(3'd1, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd0, r); check("R5 raw sticky status", r, 32'h10);

    // R8 halt master 0 with a repeated request inside the window
    clear_all();
    wr(3'd4, 32'h1);
    check("R8 hold0 start", {30'd0, master_hold}, 2'b01);
    wr(3'd4, 32'h1);
    count_hold(0, n, oth);
    check("R8 hold0 length", n, HL - 1);
    check("R8 hold1 untouched", {31'd0, oth}, 0);
    rd(3'd0, r); check("R8 halt ack m0", r, 32'h02000000);

    // R8 halt both
    clear_all();
    wr(3'd4, 32'h3);
    count_hold(0, n, oth);
    check("R8 both length", n, HL);
    check("R8 both holds together", {31'd0, oth}, 1);
    rd(3'd0, r); check("R8 halt ack both", r, 32'h06000000);

    // R9 reset master 0 only
    clear_all();
    wr(3'd5, 32'h000003F1);
    count_hold(0, n, oth);
    check("R9 m0 reset length", n, RL);
    check("R9 m1 not held", {31'd0, oth}, 0);
    rd(3'd0, r); check("R9 reset done", r, 32'h01000000);

    // R9 full controller reset
    clear_all();
    wr(3'd5, 32'h0F73F3F7);
    count_hold(1, n, oth);
    check("R9 full reset length", n, RL);
    check("R9 full reset both", {31'd0, oth}, 1);
    rd(3'd0, r); check("R9 full reset done", r, 32'h01000000);

    // R9 zero mask ignored
    clear_all();
    wr(3'd5, 32'h0);
    check("R9 zero mask no hold", {30'd0, master_hold}, 0);
    repeat (RL + 3) @(negedge clk);
    rd(3'd0, r); check("R9 zero mask no done", r, 0);

    finish_run();
  end
endmodule